// File: doc/BRIEF.md
# Shared Nibble-DRAM Access Sequencer

This block runs one DRAM access per slot of eight clocks and shares those slots between a display fetch engine and a CPU. The RAM is four bits wide, so every byte costs one row strobe and two column strobes. An eight-phase one-hot ring paces the slot. The 15-bit byte address is split into a row and two column addresses on an 8-bit multiplexed bus. The two nibbles read back are joined into one byte.

At the start of each slot the block decides who owns it. The display engine wins when a fetch is due and the NMI hold is low. A fetch is due when the slot counter is zero and the display engine raises its request (inside the pixel area and not on a spacing line). In every other case the CPU address is used, and on a CPU read the same nibble assembly returns a byte for the CPU. A due fetch always produces an advance pulse for the external display address counter, even when the NMI hold takes the slot away. This keeps the screen position aligned.

Top module: `nibble_dram_seq`

## Requirements
- R1: The phase ring is one-hot. Phase 0 is active during reset and in the first cycle after reset, the ring moves by one phase per clock, and phase 7 is followed by phase 0.
- R2: In phases 0 and 1 `ramAddr` carries the row, which is byte address bits [14:7]. `rowStrobe` is high exactly in phases 1 to 6.
- R3: `ramAddr` carries {address[6:0], 0} in phases 2 and 3 and {address[6:0], 1} in phases 4 to 7.
- R4: `colStrobe` is high exactly in phases 3, 5 and 6, and never while `rowStrobe` is low. The nibble present in phase 3 becomes bits [7:4] of `dataOut` and the nibble present in phase 6 becomes bits [3:0].
- R5: The slot goes to the display engine, using `videoAddr`, when the slot counter is 0, `videoReq` is 1 and `nmiHold` is 0, all sampled in phase 0.
- R6: Otherwise the slot uses `cpuAddr`. `cpuValid` is high for one cycle in phase 7 when `cpuRead` was 1 in phase 0. `videoValid` and `cpuValid` are never high together.
- R7: `videoValid` is high for one cycle in phase 7 of a slot granted to the display engine, with `dataOut` holding the byte from that slot.
- R8: `videoStep` is high for one cycle in phase 7 of every slot in which a fetch was due, whether or not `nmiHold` was set.
- R9: The slot counter is 0 after reset and advances once per slot, returning to 0 when its next value reaches `fetchPeriod`. A period of 1 (or 0) makes every slot due, and a period of 2 makes every second slot due.
- R10: During reset both strobes and all three pulse outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| videoAddr | input | 15 | Byte address of the next display fetch |
| cpuAddr | input | 15 | CPU byte address |
| cpuRead | input | 1 | CPU access is a read |
| videoReq | input | 1 | Display position is inside the pixel area on a non-spacing line |
| nmiHold | input | 1 | Blocks display access for this slot |
| fetchPeriod | input | 3 | Slots between display fetches |
| ramNibble | input | 4 | Data nibble from the RAM |
| ramAddr | output | 8 | Multiplexed row/column address |
| rowStrobe | output | 1 | Row select, active high |
| colStrobe | output | 1 | Column select, active high |
| dataOut | output | 8 | Assembled byte |
| videoValid | output | 1 | Byte belongs to the display engine |
| cpuValid | output | 1 | Byte belongs to a CPU read |
| videoStep | output | 1 | Advance the display address |

## Verification
The bench covers every combination of request, NMI hold and CPU read, for fetch periods 1, 2 and 3. It uses corner addresses whose row and column fields are all zeros, all ones, or differ in a single bit, so a swapped or shifted address field shows up on the bus. The request-with-NMI cases separate the grant from the advance pulse. Running the periods back to back shows that the counter gates only the display side. The RAM model returns a nibble computed from row and column, so a swapped nibble, a wrong column low bit or a stale row gives a different byte.

// File: rtl/nds_pkg.sv
package nds_pkg;
  localparam int PHASES = 8;

  typedef struct packed {
    logic takeSlot;
    logic rowDrive;
    logic col1Drive;
    logic rowStrobe;
    logic colStrobe;
    logic loadHigh;
    logic loadLow;
  } seqCtl_t;
endpackage

// File: rtl/nds_ctrl.sv
module nds_ctrl
  import nds_pkg::*;
#(
  parameter int PER_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             videoReq,
  input  logic             nmiHold,
  input  logic             cpuRead,
  input  logic [PER_W-1:0] fetchPeriod,
  output seqCtl_t          ctl,
  output logic             grantNow,
  output logic             slotVideo,
  output logic             slotDue,
  output logic             slotRead
);
  logic [PHASES-1:0] phase;
  logic [PER_W-1:0]  slotCnt;
  logic [PER_W-1:0]  cntNext;
  logic              fetchDue;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PHASES'(1);
    else        phase <= {phase[PHASES-2:0], phase[PHASES-1]};
  end

  assign fetchDue = (slotCnt == '0) && videoReq;
  assign grantNow = fetchDue && !nmiHold;
  assign cntNext  = slotCnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slotCnt   <= '0;
      slotVideo <= 1'b0;
      slotDue   <= 1'b0;
      slotRead  <= 1'b0;
    end else begin
      if (phase[0]) begin
        slotVideo <= grantNow;
        slotDue   <= fetchDue;
        slotRead  <= cpuRead;
      end
      if (phase[PHASES-1])
        slotCnt <= (cntNext >= fetchPeriod) ? '0 : cntNext;
    end
  end

  always_comb begin
    ctl.takeSlot  = phase[0];
    ctl.rowDrive  = phase[0] | phase[1];
    ctl.col1Drive = |phase[7:4];
    ctl.rowStrobe = |phase[6:1];
    ctl.colStrobe = phase[3] | phase[5] | phase[6];
    ctl.loadHigh  = phase[3];
    ctl.loadLow   = phase[6];
  end

  assert_phase_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(phase) == 1);
  assert_phase_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    phase[PHASES-1] |=> phase[0]);
  assert_phase_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    phase[0] |=> phase[1]);
  assert_period_one_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase[PHASES-1] && fetchPeriod <= PER_W'(1)) |=> slotCnt == '0);
endmodule

// File: rtl/nds_datapath.sv
module nds_datapath
  import nds_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int NIB_W  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  seqCtl_t              ctl,
  input  logic                 grantNow,
  input  logic                 slotVideo,
  input  logic                 slotDue,
  input  logic                 slotRead,
  input  logic [ADDR_W-1:0]    videoAddr,
  input  logic [ADDR_W-1:0]    cpuAddr,
  input  logic [NIB_W-1:0]     ramNibble,
  output logic [ADDR_W-8:0]    ramAddr,
  output logic                 rowStrobe,
  output logic                 colStrobe,
  output logic [2*NIB_W-1:0]   dataOut,
  output logic                 videoValid,
  output logic                 cpuValid,
  output logic                 videoStep
);
  localparam int RA_W  = ADDR_W - 7;
  localparam int COL_W = RA_W - 1;

  logic [ADDR_W-1:0] selAddr;
  logic [ADDR_W-1:0] slotAddr;
  logic [ADDR_W-1:0] curAddr;
  logic [NIB_W-1:0]  highNib;
  logic [NIB_W-1:0]  lowNib;

  assign selAddr = grantNow ? videoAddr : cpuAddr;
  assign curAddr = ctl.takeSlot ? selAddr : slotAddr;
  assign ramAddr = ctl.rowDrive ? curAddr[ADDR_W-1:COL_W]
                                : {curAddr[COL_W-1:0], ctl.col1Drive};
  assign rowStrobe = ctl.rowStrobe;
  assign colStrobe = ctl.colStrobe;
  assign dataOut   = {highNib, lowNib};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slotAddr   <= '0;
      highNib    <= '0;
      lowNib     <= '0;
      videoValid <= 1'b0;
      cpuValid   <= 1'b0;
      videoStep  <= 1'b0;
    end else begin
      if (ctl.takeSlot) slotAddr <= selAddr;
      if (ctl.loadHigh) highNib  <= ramNibble;
      if (ctl.loadLow)  lowNib   <= ramNibble;
      videoValid <= ctl.loadLow && slotVideo;
      cpuValid   <= ctl.loadLow && !slotVideo && slotRead;
      videoStep  <= ctl.loadLow && slotDue;
    end
  end

  assert_col_under_row_R4: assert property (@(posedge clk) disable iff (!rst_n)
    colStrobe |-> rowStrobe);
  assert_owner_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({videoValid, cpuValid}));
  assert_grant_implies_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    videoValid |-> videoStep);
  assert_byte_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (videoValid || cpuValid) |=> $stable(dataOut));
endmodule

// File: rtl/nibble_dram_seq.sv
module nibble_dram_seq
  import nds_pkg::*;
#(
  parameter int ADDR_W     = 15,
  parameter int NIB_W      = 4,
  parameter int MAX_PERIOD = 4,
  localparam int PER_W     = $clog2(MAX_PERIOD + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  videoAddr,
  input  logic [ADDR_W-1:0]  cpuAddr,
  input  logic               cpuRead,
  input  logic               videoReq,
  input  logic               nmiHold,
  input  logic [PER_W-1:0]   fetchPeriod,
  input  logic [NIB_W-1:0]   ramNibble,
  output logic [ADDR_W-8:0]  ramAddr,
  output logic               rowStrobe,
  output logic               colStrobe,
  output logic [2*NIB_W-1:0] dataOut,
  output logic               videoValid,
  output logic               cpuValid,
  output logic               videoStep
);
  seqCtl_t ctl;
  logic    grantNow;
  logic    slotVideo;
  logic    slotDue;
  logic    slotRead;

  nds_ctrl #(.PER_W(PER_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .videoReq(videoReq), .nmiHold(nmiHold),
    .cpuRead(cpuRead), .fetchPeriod(fetchPeriod), .ctl(ctl),
    .grantNow(grantNow), .slotVideo(slotVideo), .slotDue(slotDue),
    .slotRead(slotRead)
  );

  nds_datapath #(.ADDR_W(ADDR_W), .NIB_W(NIB_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .grantNow(grantNow),
    .slotVideo(slotVideo), .slotDue(slotDue), .slotRead(slotRead),
    .videoAddr(videoAddr), .cpuAddr(cpuAddr), .ramNibble(ramNibble),
    .ramAddr(ramAddr), .rowStrobe(rowStrobe), .colStrobe(colStrobe),
    .dataOut(dataOut), .videoValid(videoValid), .cpuValid(cpuValid),
    .videoStep(videoStep)
  );
endmodule

// File: tb/nibble_dram_seq_tb_top.sv
module nibble_dram_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [14:0] videoAddr = '0;
  logic [14:0] cpuAddr = '0;
  logic        cpuRead = 1'b0;
  logic        videoReq = 1'b0;
  logic        nmiHold = 1'b0;
  logic [2:0]  fetchPeriod = 3'd1;
  logic [3:0]  ramNibble;
  logic [7:0]  ramAddr;
  logic        rowStrobe, colStrobe, videoValid, cpuValid, videoStep;
  logic [7:0]  dataOut;
  logic [7:0]  rowLat = '0;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  int cnt = 0;

  always #4 clk = ~clk;

  nibble_dram_seq dut_i (
    .clk(clk), .rst_n(rst_n), .videoAddr(videoAddr), .cpuAddr(cpuAddr),
    .cpuRead(cpuRead), .videoReq(videoReq), .nmiHold(nmiHold),
    .fetchPeriod(fetchPeriod), .ramNibble(ramNibble), .ramAddr(ramAddr),
    .rowStrobe(rowStrobe), .colStrobe(colStrobe), .dataOut(dataOut),
    .videoValid(videoValid), .cpuValid(cpuValid), .videoStep(videoStep)
  );

  function automatic logic [3:0] memNib(input logic [7:0] row, input logic [7:0] col);
    logic [7:0] v;
    v = row * 8'd5 + col * 8'd3 + 8'd1;
    return v[3:0] ^ row[7:4];
  endfunction

  // RAM model: row captured while row select is low, column read while selected
  always @(posedge clk) if (!rowStrobe) rowLat <= ramAddr;
  assign ramNibble = colStrobe ? memNib(rowLat, ramAddr) : 4'h0;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic runSlot(input bit vReq, input bit nmi, input bit rd,
                         input logic [14:0] vA, input logic [14:0] cA,
                         input logic [2:0] per);
    bit due, grant;
    logic [14:0] a;
    logic [7:0] expByte;
    videoReq = vReq; nmiHold = nmi; cpuRead = rd;
    videoAddr = vA; cpuAddr = cA; fetchPeriod = per;
    due = (cnt == 0) && vReq;
    grant = due && !nmi;
    a = grant ? vA : cA;
    expByte = {memNib(a[14:7], {a[6:0], 1'b0}), memNib(a[14:7], {a[6:0], 1'b1})};
    for (int k = 0; k < 8; k++) begin
      logic [7:0] expAddr;
      logic [4:0] expCtl;
      #3;
      // R2 / R3: address multiplexing per phase
      if (k < 2) expAddr = a[14:7];
      else if (k < 4) expAddr = {a[6:0], 1'b0};
      else expAddr = {a[6:0], 1'b1};
      check(ramAddr == expAddr, k < 2 ? "R2 row addr" : "R3 col addr",
            32'(ramAddr), 32'(expAddr));
      // R1 R2 R4 R6 R7 R8: strobes and pulses vs phase
      expCtl = {k >= 1 && k <= 6, k == 3 || k == 5 || k == 6,
                k == 7 && grant, k == 7 && !grant && rd, k == 7 && due};
      check({rowStrobe, colStrobe, videoValid, cpuValid, videoStep} == expCtl,
            "R1 R4 R6 R7 R8 strobes/pulses", 32'({rowStrobe, colStrobe, videoValid,
            cpuValid, videoStep}), 32'(expCtl));
      if (k == 7 && (grant || rd))
        check(dataOut == expByte, grant ? "R7 R5 video byte" : "R6 cpu byte",
              32'(dataOut), 32'(expByte));
      @(negedge clk);
    end
    // R9: counter model
    cnt = ((cnt + 1) >= per) ? 0 : cnt + 1;
  endtask

  initial begin
    logic [14:0] addrs [4];
    addrs[0] = 15'h0000; addrs[1] = 15'h7FFF; addrs[2] = 15'h0080; addrs[3] = 15'h007F;
    repeat (2) @(negedge clk);
    #3;
    // R10: reset state
    check({rowStrobe, colStrobe, videoValid, cpuValid, videoStep} == 5'b0,
          "R10 reset outputs", 32'({rowStrobe, colStrobe, videoValid, cpuValid,
          videoStep}), 32'h0);
    check(ramAddr == 8'h00, "R1 R2 phase0 row at reset", 32'(ramAddr), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int p = 1; p <= 3; p++)
      for (int combo = 0; combo < 8; combo++)
        for (int ai = 0; ai < 4; ai++)
          runSlot(combo[0], combo[1], combo[2], addrs[ai], addrs[3 - ai] ^ 15'h2A55,
                  3'(p));
    // R9: period 0 behaves as every slot due
    for (int s = 0; s < 3; s++) runSlot(1'b1, 1'b0, 1'b0, 15'h1234, 15'h4321, 3'd0);
    // R8: NMI with due fetch, period 2 alternating
    for (int s = 0; s < 4; s++) runSlot(1'b1, 1'b1, 1'b1, 15'h5A5A, 15'h2BCD, 3'd2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(150000 * 8);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule